// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Engine

This block sits on the system clock and drives a three-wire serial EEPROM that holds 64 words of 16 bits. A client hands it one command at a time: an operation code, a 6-bit word address, a 16-bit write value and, for reads, a burst length. The engine produces chip select, a divided serial clock and the serial data line. It shifts the instruction out most significant bit first and returns read words one at a time, each tagged with its word address. Every accepted command ends with a single-cycle completion pulse.

A write ends by dropping chip select straight after the last data bit, which starts the memory's self-timed programming. The engine keeps select low for a minimum time, raises it again with the serial clock parked low, and watches the returned data line until it reads 1. If that never happens within a programmable number of cycles, the completion pulse carries an error flag. Reads discard the leading zero the memory sends before the first word. A burst keeps the clock running without sending the address again, so the memory's own address counter supplies the following words and wraps from 63 to 0. Enable and disable commands switch the memory's write protection.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, mw_cs, mw_sk, mw_di, done, timeout_err and rd_valid are 0 and req_ready is 1.
- R2: Each frame starts with a 1, then a 2-bit opcode, then a 6-bit address field, MSB first, and mw_di holds steady across every rising mw_sk. The req_op code selects the frame: 0 is a read (opcode 10, field = address), 1 is a write (opcode 01, field = address, then 16 data bits MSB first), 2 enables writes (opcode 00, field 110000) and 3 disables them (opcode 00, field 000000). A write sent before an enable, or after a disable, leaves the memory word unchanged.
- R3: While mw_cs is high, mw_sk is high for exactly SK_HALF cycles and low for exactly SK_HALF cycles before each rise. mw_sk is low whenever mw_cs is low.
- R4: Between any two mw_cs high periods, mw_cs stays low for at least CS_LOW_CYC cycles.
- R5: A read of N words gives 9 + 16·N rising mw_sk edges in one select period. The bit sampled on the ninth edge is dropped. rd_valid pulses N times, with rd_data MSB first and rd_addr stepping up from the request address and wrapping from 63 to 0.
- R6: A write gives exactly 25 rising mw_sk edges in its select period, so mw_cs falls before any edge after D0. It is followed by a second select period with no mw_sk edges.
- R7: During the status period, the engine drops mw_cs and pulses done with timeout_err at 0 once mw_do reads 1, ignoring the first POLL_SETTLE cycles.
- R8: If mw_do is still 0 after TIMEOUT_CYC status cycles, mw_cs falls and done pulses together with timeout_err.
- R9: req_ready is 0 from acceptance until done. A req_valid raised in that time starts no frame.
- R10: done is high for one cycle, exactly once per accepted request. A req_len of 0 reads one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Engine idle and accepting a command |
| req_op | input | 2 | 0 read, 1 write, 2 enable writes, 3 disable writes |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Value for a write |
| req_len | input | LEN_W | Words in a read burst (0 means 1) |
| rd_valid | output | 1 | One read word available |
| rd_addr | output | 6 | Address of the word on rd_data |
| rd_data | output | 16 | Read word |
| done | output | 1 | Single-cycle completion pulse |
| timeout_err | output | 1 | With done: ready was never seen |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
A bit counter off by one shows up within a single frame. The count of mw_sk rises in that select period changes, the 9-bit header seen by the memory is wrong, or a write lands on the wrong word, and a read-back exposes it on the next command. A sampling phase or receive counter that slips shifts every bit of rd_data, and the first rd_valid already shows it. A bad gap or polling state shows either as a short low period on mw_cs at the next select rise, or as done arriving with timeout_err in the wrong state.

// File: rtl/mwh_pkg.sv
package mwh_pkg;

  localparam int ADDR_W  = 6;
  localparam int WORD_W  = 16;
  localparam int HDR_W   = 1 + 2 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int BC_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WEN   = 2'd2,
    OP_WDIS  = 2'd3
  } mwh_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_CMD,
    ST_RECV,
    ST_PGAP,
    ST_POLL
  } mwh_st_e;

  // Full left-aligned frame: start bit, opcode, address field, data.
  function automatic logic [FRAME_W-1:0] mwh_frame(mwh_op_e op,
                                                    logic [ADDR_W-1:0] a,
                                                    logic [WORD_W-1:0] d);
    logic [FRAME_W-1:0] f;
    case (op)
      OP_READ:  f = {1'b1, 2'b10, a, {WORD_W{1'b0}}};
      OP_WRITE: f = {1'b1, 2'b01, a, d};
      OP_WEN:   f = {1'b1, 2'b00, 2'b11, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
      default:  f = {1'b1, 2'b00, {ADDR_W{1'b0}}, {WORD_W{1'b0}}};
    endcase
    return f;
  endfunction

  function automatic logic [BC_W-1:0] mwh_nbits(mwh_op_e op);
    return (op == OP_WRITE) ? BC_W'(FRAME_W) : BC_W'(HDR_W);
  endfunction

  function automatic logic [ADDR_W-1:0] mwh_next_addr(logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

endpackage

// File: rtl/mwh_sk_gen.sv
module mwh_sk_gen #(
  parameter int SK_HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sk_o,
  output logic bit_end_o
);
  localparam int PH_W = (2 * SK_HALF > 1) ? $clog2(2 * SK_HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * SK_HALF - 1);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(SK_HALF);

  logic [PH_W-1:0] ph, ph_nxt;

  always_comb begin
    if (!run_i)             ph_nxt = '0;
    else if (ph == PH_LAST) ph_nxt = '0;
    else                    ph_nxt = ph + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      sk_o <= 1'b0;
    end else begin
      ph   <= ph_nxt;
      sk_o <= (ph_nxt >= PH_HI);
    end
  end

  assign bit_end_o = run_i && (ph == PH_LAST);

  // R3: a bit always ends during the high half of the serial clock
  p_bitend_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |-> sk_o)
    else $error("bit end outside high half");

endmodule

// File: rtl/mwh_gap_timer.sv
module mwh_gap_timer #(
  parameter int MIN_LOW = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  output logic gap_ok_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cs_i)        cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign gap_ok_o = (cnt == CMAX);

  // R4: the gap count restarts whenever select is high
  p_gap_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i |=> !gap_ok_o)
    else $error("gap ok right after select");

endmodule

// File: rtl/mwh_rx.sv
module mwh_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_i,
  input  logic              clr_i,
  input  logic              smp_i,
  output logic              sdo_o,
  output logic              last_o,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] CLAST = CW'(WORD_W - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= do_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (clr_i) begin
        cnt <= '0;
      end else if (smp_i) begin
        word_o <= {word_o[WORD_W-2:0], s2};
        cnt    <= (cnt == CLAST) ? '0 : cnt + 1'b1;
        vld_o  <= (cnt == CLAST);
      end
    end
  end

  assign sdo_o  = s2;
  assign last_o = (cnt == CLAST);

  // R5: a finished word is reported for a single cycle
  p_word_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o)
    else $error("word strobe longer than one cycle");

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mwh_pkg::*;
#(
  parameter int SK_HALF     = 50,
  parameter int CS_LOW_CYC  = 25,
  parameter int TIMEOUT_CYC = 1100000,
  parameter int POLL_SETTLE = 4,
  parameter int LEN_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [5:0]        req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [5:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic              done,
  output logic              timeout_err,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  mwh_st_e             st;
  mwh_op_e             op_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [BC_W-1:0]     bcnt, nbits_q;
  logic [LEN_W-1:0]    words_left;
  logic [ADDR_W-1:0]   addr_q, rdaddr_q;
  logic [TMO_W-1:0]    tmo_cnt;
  logic                cs_q, di_q, done_q, err_q;

  // Named internal events
  logic req_fire, run, bit_end, gap_ok, smp, rx_clr, rx_last, sdo, rx_vld, hdr_last;
  logic [WORD_W-1:0] rx_word;

  assign req_ready = (st == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign run       = (st == ST_CMD) || (st == ST_RECV);
  assign smp       = bit_end && (st == ST_RECV);
  assign rx_clr    = (st == ST_GAP);
  assign hdr_last  = (bcnt == nbits_q - 1'b1);

  mwh_sk_gen #(.SK_HALF(SK_HALF)) u_sk (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sk_o(mw_sk), .bit_end_o(bit_end)
  );

  mwh_gap_timer #(.MIN_LOW(CS_LOW_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_q), .gap_ok_o(gap_ok)
  );

  mwh_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .do_i(mw_do), .clr_i(rx_clr), .smp_i(smp),
    .sdo_o(sdo), .last_o(rx_last), .vld_o(rx_vld), .word_o(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      op_q       <= OP_READ;
      frame_q    <= '0;
      bcnt       <= '0;
      nbits_q    <= '0;
      words_left <= '0;
      addr_q     <= '0;
      rdaddr_q   <= '0;
      tmo_cnt    <= '0;
      cs_q       <= 1'b0;
      di_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_fire) begin
            op_q       <= mwh_op_e'(req_op);
            frame_q    <= mwh_frame(mwh_op_e'(req_op), req_addr, req_wdata);
            nbits_q    <= mwh_nbits(mwh_op_e'(req_op));
            words_left <= (req_len == '0) ? LEN_W'(1) : req_len;
            addr_q     <= req_addr;
            st         <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_ok) begin
            cs_q    <= 1'b1;
            di_q    <= frame_q[FRAME_W-1];
            frame_q <= frame_q << 1;
            bcnt    <= '0;
            st      <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (bit_end) begin
            if (hdr_last) begin
              di_q <= 1'b0;
              if (op_q == OP_READ) begin
                st <= ST_RECV;
              end else if (op_q == OP_WRITE) begin
                cs_q <= 1'b0;
                st   <= ST_PGAP;
              end else begin
                cs_q   <= 1'b0;
                done_q <= 1'b1;
                st     <= ST_IDLE;
              end
            end else begin
              di_q    <= frame_q[FRAME_W-1];
              frame_q <= frame_q << 1;
              bcnt    <= bcnt + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (bit_end && rx_last) begin
            rdaddr_q <= addr_q;
            addr_q   <= mwh_next_addr(addr_q);
            if (words_left == LEN_W'(1)) begin
              cs_q   <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              words_left <= words_left - 1'b1;
            end
          end
        end
        ST_PGAP: begin
          if (gap_ok) begin
            cs_q    <= 1'b1;
            tmo_cnt <= '0;
            st      <= ST_POLL;
          end
        end
        ST_POLL: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if ((tmo_cnt >= TMO_W'(POLL_SETTLE)) && sdo) begin
            cs_q   <= 1'b0;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1)) begin
            cs_q   <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mw_cs       = cs_q;
  assign mw_di       = di_q;
  assign done        = done_q;
  assign timeout_err = err_q;
  assign rd_valid    = rx_vld;
  assign rd_data     = rx_word;
  assign rd_addr     = rdaddr_q;

  // R2: data line never moves on a rising serial clock
  p_di_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sk) |-> $stable(di_q))
    else $error("DI changed at SK rise");

  // R3: no serial clock while deselected
  p_sk_low_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !mw_sk)
    else $error("SK high with CS low");

  // R4: select rises only after the low-time counter is satisfied
  p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> $past(gap_ok))
    else $error("CS low time too short");

  // R6: select rises and falls with the serial clock parked low
  p_cs_rise_sk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> !mw_sk)
    else $error("SK not idle at CS rise");
  p_cs_fall_sk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> !mw_sk)
    else $error("SK not idle at CS fall");

  // R8: the error flag only accompanies completion
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q)
    else $error("error without done");

  // R9: an accepted command closes the request port
  p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready)
    else $error("ready right after acceptance");

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle");

endmodule

// File: tb/sim_mw_eeprom_host.sv
module sim_mw_slave #(
  parameter int BUSY_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic stuck,
  output logic dout
);
  logic [15:0] mem [64];
  logic        cs_d, sk_d, en, status, do_q;
  logic [2:0]  st;
  logic [4:0]  cnt;
  logic [7:0]  hsr;
  logic [15:0] wsr;
  logic [5:0]  ad;
  logic [3:0]  bi;
  int          busy;
  logic [7:0]  h;

  function automatic logic [15:0] init_word(logic [5:0] a);
    return {2'b11, a, 2'b00, ~a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(6'(i));
      cs_d <= 0; sk_d <= 0; en <= 0; status <= 0; do_q <= 0;
      st <= 0; cnt <= 0; hsr <= 0; wsr <= 0; ad <= 0; bi <= 0; busy <= 0;
    end else begin
      cs_d <= cs;
      sk_d <= sk;
      if (busy > 0 && !stuck) busy <= busy - 1;
      if (cs_d && !cs) begin
        if (st == 5) begin
          status <= 1;
          if (en) begin
            mem[ad] <= wsr;
            busy    <= BUSY_CYC;
          end
        end
        st <= 0;
      end else if (cs && sk && !sk_d) begin
        case (st)
          0: if (di) begin st <= 1; cnt <= 0; hsr <= 0; status <= 0; end
          1: begin
            hsr <= {hsr[6:0], di};
            cnt <= cnt + 1;
            if (cnt == 7) begin
              h = {hsr[6:0], di};
              if (h[7:6] == 2'b10) begin ad <= h[5:0]; do_q <= 0; bi <= 0; st <= 2; end
              else if (h[7:6] == 2'b01) begin ad <= h[5:0]; cnt <= 0; st <= 3; end
              else begin
                if (h[5:4] == 2'b11) en <= 1;
                else if (h[5:4] == 2'b00) en <= 0;
                st <= 4;
              end
            end
          end
          2: begin
            do_q <= mem[ad][4'd15 - bi];
            if (bi == 15) begin bi <= 0; ad <= ad + 1; end
            else bi <= bi + 1;
          end
          3: begin
            wsr <= {wsr[14:0], di};
            cnt <= cnt + 1;
            if (cnt == 15) st <= 5;
          end
          default: ;
        endcase
      end
    end
  end

  assign dout = cs ? ((st == 2) ? do_q : (status ? (busy == 0) : 1'b0)) : 1'b0;
endmodule

module sim_mw_eeprom_host;
  localparam int SKH  = 4;
  localparam int GAP  = 6;
  localparam int TMO  = 3000;
  localparam int LENW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [5:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [LENW-1:0] req_len = 0;
  logic rd_valid, done, timeout_err, mw_cs, mw_sk, mw_di, mw_do;
  logic [5:0] rd_addr;
  logic [15:0] rd_data;
  logic stuck = 0;

  always #5 clk = ~clk;

  mw_eeprom_host #(.SK_HALF(SKH), .CS_LOW_CYC(GAP), .TIMEOUT_CYC(TMO),
                   .POLL_SETTLE(4), .LEN_W(LENW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .timeout_err(timeout_err), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  sim_mw_slave #(.BUSY_CYC(400)) u_mem (
    .clk(clk), .rst_n(rst_n), .cs(mw_cs), .sk(mw_sk), .di(mw_di), .stuck(stuck), .dout(mw_do)
  );

  int checks = 0, errors = 0;
  logic [15:0] exp_mem [64];
  logic        exp_en = 0;
  logic [21:0] exp_q [$];
  int          win_rises [$];
  logic [8:0]  win_hdr [$];
  int          done_cnt = 0, sk_bad = 0, min_gap = 1000000, sk_rise_tot = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(logic [5:0] a);
    return {2'b11, a, 2'b00, ~a};
  endfunction

  // Scoreboard monitor for read words
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected word", longint'(rd_data), 0);
      else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        chk({rd_addr, rd_data} == e, "R5 read word/address", longint'({rd_addr, rd_data}), longint'(e));
      end
    end
    if (rst_n && done) done_cnt++;
  end

  // Pin monitor: select windows, clock widths, gaps, header bits
  logic cs_p = 0, sk_p = 0, seen_win = 0;
  int   rises = 0, hcnt = 0, hi_len = 0, lo_len = 0, gap_len = 0;
  logic [8:0] hdr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_cs && !cs_p) begin
        if (seen_win && gap_len < min_gap) min_gap = gap_len;
        seen_win = 1; rises = 0; hcnt = 0; hdr = 0; lo_len = 0; hi_len = 0;
      end
      if (!mw_cs && cs_p) begin
        win_rises.push_back(rises);
        win_hdr.push_back(hdr);
        gap_len = 0;
      end
      if (!mw_cs && mw_sk) sk_bad++;
      if (sk_p && !mw_sk && hi_len != SKH) sk_bad++;
      if (mw_cs && mw_sk && !sk_p) begin
        if (lo_len != SKH) sk_bad++;
        rises++; sk_rise_tot++;
        if (hcnt < 9) begin hdr = {hdr[7:0], mw_di}; hcnt++; end
      end
      if (mw_sk) begin hi_len = (sk_p ? hi_len : 0) + 1; end
      else if (mw_cs) begin lo_len = (sk_p || (mw_cs && !cs_p) ? 0 : lo_len) + 1; end
      if (!mw_cs) gap_len++;
      cs_p = mw_cs; sk_p = mw_sk;
    end
  end

  task automatic issue(input int op, input int a, input logic [15:0] d, input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 2'(op); req_addr = 6'(a); req_wdata = d; req_len = LENW'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output logic err);
    err = 0;
    forever begin
      if (done) begin err = timeout_err; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [8:0] hdr_exp(int op, int a);
    case (op)
      0: return {3'b110, 6'(a)};
      1: return {3'b101, 6'(a)};
      2: return 9'b100_110000;
      default: return 9'b100_000000;
    endcase
  endfunction

  task automatic cmd(input int op, input int a, input logic [15:0] d, input int len,
                     input string req, input logic exp_err);
    logic err; int n; int d0;
    win_rises.delete(); win_hdr.delete();
    d0 = done_cnt;
    if (op == 0) begin
      n = (len == 0) ? 1 : len;
      for (int i = 0; i < n; i++)
        exp_q.push_back({6'(a + i), exp_mem[6'(a + i)]});
    end
    if (op == 1 && exp_en) exp_mem[a] = d;
    if (op == 2) exp_en = 1;
    if (op == 3) exp_en = 0;
    issue(op, a, d, len);
    wait_done(err);
    repeat (3) @(negedge clk);
    chk(err == exp_err, {req, " timeout flag"}, longint'(err), longint'(exp_err));
    chk(done_cnt - d0 == 1, "R10 one done per command", done_cnt - d0, 1);
    chk(win_hdr.size() > 0 && win_hdr[0] == hdr_exp(op, a), {"R2 header ", req},
        win_hdr.size() > 0 ? longint'(win_hdr[0]) : -1, longint'(hdr_exp(op, a)));
    if (op == 0) begin
      n = (len == 0) ? 1 : len;
      chk(win_rises.size() == 1 && win_rises[0] == 9 + 16 * n, "R5 SK rises in read",
          win_rises.size() > 0 ? win_rises[0] : -1, 9 + 16 * n);
      chk(exp_q.size() == 0, "R5 all words returned", exp_q.size(), 0);
    end else if (op == 1) begin
      chk(win_rises.size() == 2 && win_rises[0] == 25 && win_rises[1] == 0,
          "R6 write then idle status window",
          win_rises.size() > 0 ? win_rises[0] : -1, 25);
    end else begin
      chk(win_rises.size() == 1 && win_rises[0] == 9, "R2 short frame rises",
          win_rises.size() > 0 ? win_rises[0] : -1, 9);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(6'(i));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({mw_cs, mw_sk, mw_di, done, timeout_err, rd_valid} == 0, "R1 outputs at reset",
        longint'({mw_cs, mw_sk, mw_di, done, timeout_err, rd_valid}), 0);
    chk(req_ready == 1, "R1 ready at reset", longint'(req_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cmd(0, 3, 0, 1, "R5 single read", 0);
    cmd(1, 5, 16'h1234, 0, "R2 write while protected", 0);
    cmd(0, 5, 0, 1, "R2 protected word unchanged", 0);
    cmd(2, 0, 0, 0, "R2 enable", 0);
    cmd(1, 5, 16'hBEEF, 0, "R7 write ready", 0);
    cmd(1, 63, 16'h1357, 0, "R7 write top", 0);
    cmd(1, 0, 16'h2468, 0, "R7 write bottom", 0);
    cmd(0, 5, 0, 1, "R7 read back", 0);
    cmd(0, 61, 0, 5, "R5 wrapping burst", 0);
    cmd(0, 5, 0, 0, "R10 zero length", 0);

    // R9: requests while busy are refused and start nothing
    begin
      logic err; int bad_ready = 0;
      win_rises.delete(); win_hdr.delete();
      for (int i = 0; i < 3; i++) exp_q.push_back({6'(10 + i), exp_mem[10 + i]});
      issue(0, 10, 0, 3);
      @(negedge clk);
      req_op = 2'd1; req_addr = 6'd11; req_wdata = 16'hFFFF; req_valid = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (req_ready) bad_ready++;
      end
      req_valid = 0;
      chk(bad_ready == 0, "R9 ready low while busy", bad_ready, 0);
      wait_done(err);
      repeat (GAP + 4) @(negedge clk);
      chk(win_rises.size() == 1, "R9 no extra frame", win_rises.size(), 1);
    end
    cmd(0, 11, 0, 1, "R9 word untouched", 0);

    cmd(3, 0, 0, 0, "R2 disable", 0);
    cmd(1, 5, 16'h0000, 0, "R2 write after disable", 0);
    cmd(0, 5, 0, 1, "R2 disabled write ignored", 0);

    // R8: memory never reports ready
    cmd(2, 0, 0, 0, "R2 enable again", 0);
    stuck = 1;
    cmd(1, 20, 16'hA5A5, 0, "R8 timeout", 1);
    stuck = 0;
    repeat (500) @(negedge clk);
    cmd(0, 20, 0, 2, "R8 read after timeout", 0);

    chk(sk_bad == 0 && sk_rise_tot > 0, "R3 SK widths and idle", sk_bad, 0);
    chk(min_gap >= GAP, "R4 CS low time", min_gap, GAP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule